// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer ALU

This block applies one element-wise integer or bitwise operation to two 128-bit operands, `opn` and `opm`. For arithmetic and predicate operations the operands are cut into equal lanes of 8, 16 or 32 bits, and each lane is processed independently. A carry or borrow never crosses from one lane into the next. Predicates return a full lane mask of all ones or all zeros, not a single flag bit. Two operations ignore lanes and work on all 128 bits: bitwise select, which uses the current destination value `dest` as its mask, and bitwise NOT of `opm`.

A caller presents the operands, the destination value, an operation code and a lane-size code, and pulses `in_valid`. The result, the output strobe and an illegal-request flag are registered and appear one clock later. A lane-size code the block does not support, when combined with an operation that depends on lane size, is rejected the same way as an unknown operation code.

Top module: `simd_lane_alu`

## Requirements
- R1: The operation code is encoded as add=0, subtract=1, bit-test=2, compare-equal=3, select=4, NOT=5. The size code is encoded as 0 = sixteen 8-bit lanes, 1 = eight 16-bit lanes, 2 = four 32-bit lanes. Lane k of a W-bit lane size occupies bits [k*W+W-1 : k*W].
- R2: Add gives, for every lane, (opn + opm) mod 2^W. No carry passes into the neighbouring lane.
- R3: Subtract gives, for every lane, (opn - opm) mod 2^W. No borrow passes into the neighbouring lane.
- R4: Bit-test sets a lane to all ones when the AND of its opn and opm lanes is nonzero, and to all zeros otherwise.
- R5: Compare-equal sets a lane to all ones when its opn and opm lanes are equal, and to all zeros otherwise.
- R6: Select gives (dest AND opn) OR (NOT dest AND opm) over all 128 bits, for any size code including 3, with `illegal` low.
- R7: NOT gives the bitwise inverse of opm over all 128 bits, for any size code including 3, with `illegal` low.
- R8: Size code 3 with any of the operations 0 to 3 gives `illegal` = 1 and a result of zero.
- R9: Operation codes 6 and 7 give `illegal` = 1 and a result of zero, whatever the size code.
- R10: `out_valid`, `result` and `illegal` reflect a request one clock edge after it is accepted with `in_valid` high, and back-to-back requests are each answered in turn. On a cycle with `in_valid` low, the next edge drives `out_valid` and `illegal` low and leaves `result` unchanged.
- R11: While `rst_n` is low, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation code (R1) |
| size_code | input | 2 | Lane size code (R1) |
| opn | input | 128 | First operand |
| opm | input | 128 | Second operand |
| dest | input | 128 | Current destination value, used as the select mask |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | Registered result |
| illegal | output | 1 | Request was rejected; the result is zero |

## Verification
The assertions check the timing contract on every cycle: the strobe latency, that the result holds while no request is accepted, and that `illegal` always comes with a zero result. They also check that unsupported requests raise the flag, and the full-width select and NOT results, because these follow directly from the registered inputs. Lane arithmetic depends on the size code: whether a carry stops at a lane boundary, borrows out of a zero lane, and which lane receives a predicate mask. The bench's scenarios show these with directed boundary operands and with random operands compared against a lane-by-lane reference model.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_TST = 3'd2;
  localparam logic [2:0] OP_CEQ = 3'd3;
  localparam logic [2:0] OP_SEL = 3'd4;
  localparam logic [2:0] OP_NOT = 3'd5;

  localparam logic [1:0] SZ_8  = 2'd0;
  localparam logic [1:0] SZ_16 = 2'd1;
  localparam logic [1:0] SZ_32 = 2'd2;
  localparam int unsigned NUM_SIZES = 3;

  // True when byte position idx opens a new lane for the given size code.
  function automatic logic lane_opens(input int unsigned idx, input logic [1:0] sz);
    case (sz)
      SZ_16:   lane_opens = (idx % 2) == 0;
      SZ_32:   lane_opens = (idx % 4) == 0;
      default: lane_opens = 1'b1;
    endcase
  endfunction

  // Operations whose result depends on the lane size.
  function automatic logic op_uses_lanes(input logic [2:0] op);
    op_uses_lanes = (op <= OP_CEQ);
  endfunction

  function automatic logic op_defined(input logic [2:0] op);
    op_defined = (op <= OP_NOT);
  endfunction

  function automatic logic [127:0] bit_select(input logic [127:0] mask,
                                               input logic [127:0] a,
                                               input logic [127:0] b);
    bit_select = (mask & a) | (~mask & b);
  endfunction
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [1:0]        size_code,
  input  logic              sub_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  logic [NBYTES-1:0] byte_cout;
  logic [NBYTES-1:0] byte_cin;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] b_eff;
    assign b_eff = sub_en ? ~b[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];

    if (i == 0) begin : g_first
      assign byte_cin[i] = sub_en;
    end else begin : g_rest
      // A lane boundary cuts the chain and reloads the subtract carry-in.
      assign byte_cin[i] = lane_opens(i, size_code) ? sub_en : byte_cout[i-1];
    end

    if (i < NBYTES - 1) begin : g_mid
      assign {byte_cout[i], sum[i*BYTE_W +: BYTE_W]} =
        {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, byte_cin[i]};
    end else begin : g_top
      assign sum[i*BYTE_W +: BYTE_W] =
        a[i*BYTE_W +: BYTE_W] + b_eff + {{(BYTE_W-1){1'b0}}, byte_cin[i]};
      assign byte_cout[i] = 1'b0;
    end
  end
endmodule

// File: rtl/simd_lane_pred.sv
module simd_lane_pred
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] tst_mask,
  output logic [DATA_W-1:0] eq_mask
);
  logic [DATA_W-1:0] tst_by_sz [NUM_SIZES];
  logic [DATA_W-1:0] eq_by_sz  [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
    localparam int unsigned LW = 8 << s;
    localparam int unsigned NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign tst_by_sz[s][l*LW +: LW] = {LW{|(a[l*LW +: LW] & b[l*LW +: LW])}};
      assign eq_by_sz[s][l*LW +: LW]  = {LW{a[l*LW +: LW] == b[l*LW +: LW]}};
    end
  end

  always_comb begin
    case (size_code)
      SZ_8:    begin tst_mask = tst_by_sz[0]; eq_mask = eq_by_sz[0]; end
      SZ_16:   begin tst_mask = tst_by_sz[1]; eq_mask = eq_by_sz[1]; end
      SZ_32:   begin tst_mask = tst_by_sz[2]; eq_mask = eq_by_sz[2]; end
      default: begin tst_mask = '0;           eq_mask = '0;           end
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        opcode,
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] opn,
  input  logic [DATA_W-1:0] opm,
  input  logic [DATA_W-1:0] dest,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] tst_res;
  logic [DATA_W-1:0] eq_res;
  logic [DATA_W-1:0] next_result;
  logic              illegal_comb;
  logic              is_sub;

  assign is_sub       = (opcode == OP_SUB);
  assign illegal_comb = !op_defined(opcode) ||
                        (op_uses_lanes(opcode) && size_code == 2'd3);

  simd_lane_addsub #(.DATA_W(DATA_W)) u_addsub (
    .size_code (size_code),
    .sub_en    (is_sub),
    .a         (opn),
    .b         (opm),
    .sum       (arith_res)
  );

  simd_lane_pred #(.DATA_W(DATA_W)) u_pred (
    .size_code (size_code),
    .a         (opn),
    .b         (opm),
    .tst_mask  (tst_res),
    .eq_mask   (eq_res)
  );

  always_comb begin
    case (opcode)
      OP_ADD, OP_SUB: next_result = arith_res;
      OP_TST:         next_result = tst_res;
      OP_CEQ:         next_result = eq_res;
      OP_SEL:         next_result = bit_select(dest, opn, opm);
      OP_NOT:         next_result = ~opm;
      default:        next_result = '0;
    endcase
    if (illegal_comb) next_result = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && illegal_comb;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        opcode,
  input logic [1:0]        size_code,
  input logic [DATA_W-1:0] opn,
  input logic [DATA_W-1:0] opm,
  input logic [DATA_W-1:0] dest,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !illegal);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0) && out_valid);
  // R8
  size3_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= 3'd3 && size_code == 2'd3) |=> illegal);
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 3'd6) |=> illegal);
  // R7
  not_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd5) |=> !illegal && (result == ~$past(opm)));
  // R6
  sel_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd4) |=> !illegal &&
      (result == (($past(dest) & $past(opn)) | (~$past(dest) & $past(opm)))));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .size_code (size_code),
  .opn       (opn),
  .opm       (opm),
  .dest      (dest),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/tb_simd_lane_alu.sv
`timescale 1ns/1ps
module tb_simd_lane_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   opcode = '0;
  logic [1:0]   size_code = '0;
  logic [127:0] opn = '0, opm = '0, dest = '0;
  logic         out_valid, illegal;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_lane_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .size_code(size_code), .opn(opn), .opm(opm), .dest(dest),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic ref_ill(input logic [2:0] op, input logic [1:0] sz);
    return (op > 3'd5) || (op <= 3'd3 && sz == 2'd3);
  endfunction

  function automatic logic [127:0] ref_alu(input logic [2:0] op, input logic [1:0] sz,
                                           input logic [127:0] n, input logic [127:0] m,
                                           input logic [127:0] d);
    logic [127:0] res, mask, an, am, v;
    int w;
    if (ref_ill(op, sz)) return '0;
    if (op == 3'd4) return (d & n) | (~d & m);
    if (op == 3'd5) return ~m;
    w = 8 << sz;
    mask = (128'd1 << w) - 128'd1;
    res = '0;
    for (int l = 0; l < 128 / w; l++) begin
      an = (n >> (l * w)) & mask;
      am = (m >> (l * w)) & mask;
      case (op)
        3'd0:    v = (an + am) & mask;
        3'd1:    v = (an - am) & mask;
        3'd2:    v = ((an & am) != 0) ? mask : '0;
        default: v = (an == am) ? mask : '0;
      endcase
      res = res | (v << (l * w));
    end
    return res;
  endfunction

  task automatic chk128(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one request; return at the following falling edge with outputs settled.
  task automatic issue(input logic [2:0] op, input logic [1:0] sz,
                       input logic [127:0] n, input logic [127:0] m, input logic [127:0] d);
    @(negedge clk);
    opcode = op; size_code = sz; opn = n; opm = m; dest = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_ref(input string tag, input logic [2:0] op, input logic [1:0] sz,
                         input logic [127:0] n, input logic [127:0] m, input logic [127:0] d);
    issue(op, sz, n, m, d);
    chk1({tag, " out_valid"}, out_valid, 1'b1);
    chk1({tag, " illegal"}, illegal, ref_ill(op, sz));
    chk128({tag, " result"}, result, ref_alu(op, sz, n, m, d));
  endtask

  task automatic t_reset();
    // R11
    chk1("R11 reset out_valid", out_valid, 1'b0);
    chk1("R11 reset illegal", illegal, 1'b0);
    chk128("R11 reset result", result, '0);
  endtask

  task automatic t_add();
    logic [127:0] ones = '1;
    logic [127:0] inc = {16{8'h01}};
    // R2 / R1: the carry stops at each lane boundary
    issue(3'd0, 2'd0, ones, inc, '0); chk128("R2 add 8-bit wrap", result, '0);
    issue(3'd0, 2'd1, ones, inc, '0); chk128("R2 add 16-bit lanes", result, {8{16'h0100}});
    issue(3'd0, 2'd2, ones, inc, '0); chk128("R2 add 32-bit lanes", result, {4{32'h01010100}});
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++)
        run_ref("R2 add random", 3'd0, 2'(s), rnd128(), rnd128(), '0);
  endtask

  task automatic t_sub();
    logic [127:0] one = {16{8'h01}};
    // R3: n - m, borrow stays inside its lane
    issue(3'd1, 2'd0, '0, one, '0); chk128("R3 sub 8-bit borrow", result, {16{8'hFF}});
    issue(3'd1, 2'd1, '0, one, '0); chk128("R3 sub 16-bit borrow", result, {8{16'hFEFF}});
    issue(3'd1, 2'd2, '0, one, '0); chk128("R3 sub 32-bit borrow", result, {4{32'hFEFEFEFF}});
    issue(3'd1, 2'd2, {4{32'd5}}, {4{32'd3}}, '0); chk128("R3 sub order", result, {4{32'd2}});
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++)
        run_ref("R3 sub random", 3'd1, 2'(s), rnd128(), rnd128(), '0);
  endtask

  task automatic t_tst();
    // R4
    issue(3'd2, 2'd0, 128'h1, 128'h1, '0); chk128("R4 tst 8-bit lane0", result, 128'hFF);
    issue(3'd2, 2'd1, 128'h1, 128'h1, '0); chk128("R4 tst 16-bit lane0", result, 128'hFFFF);
    issue(3'd2, 2'd2, 128'h1, 128'h1, '0); chk128("R4 tst 32-bit lane0", result, 128'hFFFF_FFFF);
    issue(3'd2, 2'd0, {16{8'h55}}, {16{8'hAA}}, '0); chk128("R4 tst disjoint", result, '0);
    for (int s = 0; s < 3; s++)
      run_ref("R4 tst random", 3'd2, 2'(s), rnd128() & rnd128(), rnd128() & rnd128(), '0);
  endtask

  task automatic t_ceq();
    logic [127:0] v = rnd128();
    // R5
    issue(3'd3, 2'd0, v, v, '0); chk128("R5 ceq all equal", result, '1);
    issue(3'd3, 2'd0, v, v ^ 128'h100, '0); chk128("R5 ceq 8-bit lane1", result, ~(128'hFF << 8));
    issue(3'd3, 2'd1, v, v ^ 128'h100, '0); chk128("R5 ceq 16-bit lane0", result, ~128'hFFFF);
    issue(3'd3, 2'd2, v, v ^ 128'h100, '0); chk128("R5 ceq 32-bit lane0", result, ~128'hFFFF_FFFF);
  endtask

  task automatic t_sel_not();
    for (int s = 0; s < 4; s++) begin
      run_ref("R6 select", 3'd4, 2'(s), rnd128(), rnd128(), rnd128());
      run_ref("R7 not", 3'd5, 2'(s), rnd128(), rnd128(), rnd128());
    end
  endtask

  task automatic t_illegal();
    // R8: size code 3 with lane-dependent ops
    for (int op = 0; op < 4; op++) begin
      issue(3'(op), 2'd3, rnd128(), rnd128(), rnd128());
      chk1("R8 size3 illegal", illegal, 1'b1);
      chk128("R8 size3 zero", result, '0);
    end
    // R9: undefined operation codes
    for (int op = 6; op < 8; op++) begin
      issue(3'(op), 2'd0, rnd128(), rnd128(), rnd128());
      chk1("R9 bad op illegal", illegal, 1'b1);
      chk128("R9 bad op zero", result, '0);
    end
    run_ref("R8 recovery", 3'd0, 2'd0, rnd128(), rnd128(), '0);
  endtask

  task automatic t_timing();
    logic [127:0] a = rnd128(), b = rnd128(), c = rnd128(), d = rnd128();
    logic [127:0] held;
    // R10: back-to-back requests
    @(negedge clk);
    opcode = 3'd0; size_code = 2'd1; opn = a; opm = b; in_valid = 1'b1;
    @(negedge clk);
    chk128("R10 first of pair", result, ref_alu(3'd0, 2'd1, a, b, '0));
    opcode = 3'd1; size_code = 2'd2; opn = c; opm = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk1("R10 second valid", out_valid, 1'b1);
    chk128("R10 second of pair", result, ref_alu(3'd1, 2'd2, c, d, '0));
    held = result;
    // R10: inputs change while idle; nothing moves
    opcode = 3'd5; opm = rnd128();
    repeat (3) @(negedge clk);
    chk1("R10 idle out_valid", out_valid, 1'b0);
    chk1("R10 idle illegal", illegal, 1'b0);
    chk128("R10 idle hold", result, held);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_tst();
    t_ceq();
    t_sel_not();
    t_illegal();
    t_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule